// File: doc/BRIEF.md
# Extended Capability List Walker

This block walks the chain of extended capability headers in a 4 KiB configuration memory. It has two commands. A search looks for the first header that carries a given 16-bit identifier. An append places a new header at a given byte offset and links it into the chain. The block reaches the memory through a 32-bit word port with one-cycle read latency. It only reads and writes header words. The bodies of the capabilities belong to the caller.

A command enters on a valid/ready pair. `cmd_ready` is high only while the engine is idle, and a command is taken on a rising clock edge where `cmd_valid` and `cmd_ready` are both high. The answer leaves on a second valid/ready pair. `rsp_valid` stays high, with `rsp_err`, `rsp_off` and `rsp_prev` frozen, until the edge where `rsp_ready` is seen high. Only then does the engine accept the next command. A caller that holds `rsp_ready` low stalls the block without losing anything.

A walk always starts at the list head, byte offset 256. It follows the next pointer of each header and visits at most `MAX_STEPS` headers. A pointer that leaves the legal window, is not word aligned, or still points onward after the step budget is spent ends the command with an error.

Top module: `ecap_walker`

## Requirements
- R1: After reset, and whenever no command is in progress, `cmd_ready` is 1, `rsp_valid` is 0 and neither `mem_rd_en` nor `mem_wr_en` is asserted.
- R2: If the word at the head offset 256 reads as all zeros, the list is empty. A search then answers `rsp_off`=0 and `rsp_prev`=0 with no error.
- R3: A header word holds the identifier in bits 15:0, the version in bits 19:16 and the next byte offset in bits 31:20. A next offset of 0 marks the last entry.
- R4: A search (`cmd_op`=0) with a nonzero key stops at the first header whose identifier equals the key. It answers with that offset and the offset of the entry before it, which is 0 when the match is the head.
- R5: A search with key 0, or with a key that no entry carries, runs to the last entry. It answers `rsp_off`=0 and puts the offset of that last entry in `rsp_prev`.
- R6: A followed next pointer must lie between 256 and 4088 inclusive and be a multiple of 4. Otherwise the command ends with `rsp_err`=1.
- R7: An append (`cmd_op`=1) at offset 256 writes the new identifier and version at the head. It keeps the next field already stored there. It answers `rsp_off`=256 and `rsp_prev`=0.
- R8: An append at any other offset takes two writes. First it rewrites only bits 31:20 of the last entry's header, setting them to the new offset. Then it writes the new header with next field 0. It answers with the new offset and the offset of the former last entry.
- R9: An append is rejected with `rsp_err`=1 and no memory write in any of these cases:
  - its size is below 8;
  - offset plus size is 4096 or more;
  - its offset is below 256 or not a multiple of 4;
  - its offset is not 256 and the list is empty.
- R10: A walk that has read `MAX_STEPS` headers and would still follow a nonzero next pointer ends with `rsp_err`=1, so a pointer cycle cannot hang the engine.
- R11: While `rsp_valid` is 1 and `rsp_ready` is 0, the response fields hold their values. An error response carries `rsp_off`=0 and `rsp_prev`=0.
- R12: Read data is taken one cycle after `mem_rd_en`. The engine never asserts a read and a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_op | input | 1 | 0 search, 1 append |
| cmd_id | input | 16 | Search key or identifier to append |
| cmd_ver | input | 4 | Version of the appended header |
| cmd_off | input | 12 | Byte offset of the appended header |
| cmd_size | input | 13 | Byte size of the appended capability |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Caller takes the response |
| rsp_err | output | 1 | Command failed |
| rsp_off | output | 12 | Found or appended offset, 0 if none |
| rsp_prev | output | 12 | Offset of the preceding entry, 0 if none |
| mem_rd_en | output | 1 | Read strobe |
| mem_wr_en | output | 1 | Write strobe |
| mem_addr | output | 10 | Word address (byte offset divided by 4) |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after `mem_rd_en` |

## Verification
Some rules are checked on every cycle by the assertions:
- the idle state issues no memory access and the two handshakes never overlap;
- a response holds steady while it waits and an error response reports zero offsets;
- every read address stays inside the legal header window;
- every next pointer written to a non-head word is word aligned.

The bench scenarios are the only place where the rest can show:
- which entry a search finds, and that it finds the first of two with the same identifier;
- which tail is reported;
- the exact words an append leaves in memory, including that the head's next field is kept;
- that a rejected append leaves memory untouched;
- that a pointer cycle is caught.

// File: rtl/ecap_pkg.sv
package ecap_pkg;

  localparam int HDR_ID_W  = 16;
  localparam int HDR_VER_W = 4;
  localparam int HDR_NXT_W = 12;

  // Header word layout: next offset on top, then version, identifier at bit 0.
  typedef struct packed {
    logic [HDR_NXT_W-1:0] nxt;
    logic [HDR_VER_W-1:0] ver;
    logic [HDR_ID_W-1:0]  id;
  } ecap_hdr_t;

  typedef enum logic {
    OP_FIND = 1'b0,
    OP_ADD  = 1'b1
  } ecap_op_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RD      = 3'd1,
    ST_EVAL    = 3'd2,
    ST_WR_TAIL = 3'd3,
    ST_WR_NEW  = 3'd4,
    ST_RESP    = 3'd5
  } walk_state_e;

endpackage

// File: rtl/ecap_add_check.sv
module ecap_add_check #(
  parameter int CFG_BYTES = 4096,
  parameter int BASE_OFF  = 256,
  parameter int MIN_SIZE  = 8,
  parameter int OFF_W     = 12,
  parameter int SIZE_W    = 13
) (
  input  logic [OFF_W-1:0]  off,
  input  logic [SIZE_W-1:0] size,
  output logic              ok
);
  localparam int END_W = SIZE_W + 1;

  logic [END_W-1:0] end_v;

  // Legality of an append request, judged before any memory access (R9).
  always_comb begin
    end_v = END_W'(off) + END_W'(size);
    ok    = (size >= SIZE_W'(MIN_SIZE))
         && (end_v < END_W'(CFG_BYTES))
         && (off >= OFF_W'(BASE_OFF))
         && (off[1:0] == 2'b00);
  end
endmodule

// File: rtl/ecap_hop_eval.sv
module ecap_hop_eval
  import ecap_pkg::*;
#(
  parameter int CFG_BYTES = 4096,
  parameter int BASE_OFF  = 256,
  parameter int OFF_W     = 12
) (
  input  ecap_hdr_t            hdr,
  input  logic [OFF_W-1:0]     cur,
  input  logic [HDR_ID_W-1:0]  key,
  input  logic                 match_en,
  output logic                 at_void,
  output logic                 match,
  output logic                 tail,
  output logic                 bad_link
);
  localparam int LAST_OFF = CFG_BYTES - 8;

  // Classification of one header just read from memory.
  always_comb begin
    at_void  = (cur == OFF_W'(BASE_OFF)) && (hdr == '0);
    match    = match_en && (hdr.id == key);
    tail     = (hdr.nxt == '0);
    bad_link = (hdr.nxt < HDR_NXT_W'(BASE_OFF))
            || (hdr.nxt > HDR_NXT_W'(LAST_OFF))
            || (hdr.nxt[1:0] != 2'b00);
  end
endmodule

// File: rtl/ecap_walk_seq.sv
module ecap_walk_seq
  import ecap_pkg::*;
#(
  parameter int BASE_OFF  = 256,
  parameter int MAX_STEPS = 1024,
  parameter int OFF_W     = 12,
  parameter int SIZE_W    = 13
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  output logic                  cmd_ready,
  input  logic                  cmd_op,
  input  logic [HDR_ID_W-1:0]   cmd_id,
  input  logic [HDR_VER_W-1:0]  cmd_ver,
  input  logic [OFF_W-1:0]      cmd_off,
  input  logic                  add_ok,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic                  rsp_err,
  output logic [OFF_W-1:0]      rsp_off,
  output logic [OFF_W-1:0]      rsp_prev,
  output logic                  mem_rd_en,
  output logic                  mem_wr_en,
  output logic [OFF_W-3:0]      mem_addr,
  output logic [31:0]           mem_wdata,
  input  logic [31:0]           mem_rdata,
  output logic [OFF_W-1:0]      cur_off,
  output logic [HDR_ID_W-1:0]   key,
  output logic                  match_en,
  input  logic                  ev_void,
  input  logic                  ev_match,
  input  logic                  ev_tail,
  input  logic                  ev_bad
);
  localparam int STEP_W = $clog2(MAX_STEPS + 1);

  walk_state_e          st_q;
  ecap_op_e             op_q;
  logic [HDR_ID_W-1:0]  id_q;
  logic [HDR_VER_W-1:0] ver_q;
  logic [OFF_W-1:0]     off_q;
  logic [OFF_W-1:0]     cur_q;
  logic [OFF_W-1:0]     prev_q;
  ecap_hdr_t            tail_hdr_q;
  logic [HDR_NXT_W-1:0] new_nxt_q;
  logic [STEP_W-1:0]    steps_q;
  logic                 res_err_q;
  logic [OFF_W-1:0]     res_off_q;
  logic [OFF_W-1:0]     res_prev_q;

  ecap_hdr_t hdr;
  logic      off_is_base;
  logic      limit_hit;

  assign hdr         = ecap_hdr_t'(mem_rdata);
  assign off_is_base = (off_q == OFF_W'(BASE_OFF));
  assign limit_hit   = (steps_q >= STEP_W'(MAX_STEPS - 1));
  assign cur_off     = cur_q;
  assign key         = id_q;
  assign match_en    = (op_q == OP_FIND) && (id_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      op_q       <= OP_FIND;
      id_q       <= '0;
      ver_q      <= '0;
      off_q      <= '0;
      cur_q      <= '0;
      prev_q     <= '0;
      tail_hdr_q <= '0;
      new_nxt_q  <= '0;
      steps_q    <= '0;
      res_err_q  <= 1'b0;
      res_off_q  <= '0;
      res_prev_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (cmd_valid) begin
            op_q       <= ecap_op_e'(cmd_op);
            id_q       <= cmd_id;
            ver_q      <= cmd_ver;
            off_q      <= cmd_off;
            cur_q      <= OFF_W'(BASE_OFF);
            prev_q     <= '0;
            steps_q    <= '0;
            res_err_q  <= 1'b0;
            res_off_q  <= '0;
            res_prev_q <= '0;
            if ((ecap_op_e'(cmd_op) == OP_ADD) && !add_ok) begin
              res_err_q <= 1'b1;
              st_q      <= ST_RESP;
            end else begin
              st_q <= ST_RD;
            end
          end
        end
        ST_RD: st_q <= ST_EVAL;
        ST_EVAL: begin
          steps_q <= steps_q + 1'b1;
          if ((op_q == OP_ADD) && off_is_base) begin
            new_nxt_q <= hdr.nxt;
            st_q      <= ST_WR_NEW;
          end else if (ev_void) begin
            res_err_q <= (op_q == OP_ADD);
            st_q      <= ST_RESP;
          end else if (ev_match) begin
            res_off_q  <= cur_q;
            res_prev_q <= prev_q;
            st_q       <= ST_RESP;
          end else if (ev_tail) begin
            if (op_q == OP_FIND) begin
              res_prev_q <= cur_q;
              st_q       <= ST_RESP;
            end else begin
              tail_hdr_q <= hdr;
              new_nxt_q  <= '0;
              st_q       <= ST_WR_TAIL;
            end
          end else if (ev_bad || limit_hit) begin
            res_err_q <= 1'b1;
            st_q      <= ST_RESP;
          end else begin
            prev_q <= cur_q;
            cur_q  <= OFF_W'(hdr.nxt);
            st_q   <= ST_RD;
          end
        end
        ST_WR_TAIL: st_q <= ST_WR_NEW;
        ST_WR_NEW: begin
          res_off_q  <= off_q;
          res_prev_q <= off_is_base ? '0 : cur_q;
          st_q       <= ST_RESP;
        end
        ST_RESP: begin
          if (rsp_ready) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd_ready = (st_q == ST_IDLE);
    rsp_valid = (st_q == ST_RESP);
    rsp_err   = res_err_q;
    rsp_off   = res_off_q;
    rsp_prev  = res_prev_q;
    mem_rd_en = (st_q == ST_RD);
    mem_wr_en = (st_q == ST_WR_TAIL) || (st_q == ST_WR_NEW);
    mem_addr  = cur_q[OFF_W-1:2];
    mem_wdata = '0;
    if (st_q == ST_WR_TAIL) begin
      // Only the link field of the old tail changes.
      mem_wdata = {HDR_NXT_W'(off_q), tail_hdr_q.ver, tail_hdr_q.id};
    end else if (st_q == ST_WR_NEW) begin
      mem_addr  = off_q[OFF_W-1:2];
      mem_wdata = {new_nxt_q, ver_q, id_q};
    end
  end
endmodule

// File: rtl/ecap_walker.sv
module ecap_walker
  import ecap_pkg::*;
#(
  parameter int CFG_BYTES = 4096,
  parameter int BASE_OFF  = 256,
  parameter int MAX_STEPS = 1024,
  parameter int MIN_SIZE  = 8,
  localparam int OFF_W    = $clog2(CFG_BYTES),
  localparam int SIZE_W   = OFF_W + 1,
  localparam int WA_W     = OFF_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_op,
  input  logic [15:0]       cmd_id,
  input  logic [3:0]        cmd_ver,
  input  logic [OFF_W-1:0]  cmd_off,
  input  logic [SIZE_W-1:0] cmd_size,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_err,
  output logic [OFF_W-1:0]  rsp_off,
  output logic [OFF_W-1:0]  rsp_prev,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [WA_W-1:0]   mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata
);
  logic                add_ok;
  logic [OFF_W-1:0]    cur_off;
  logic [HDR_ID_W-1:0] key;
  logic                match_en;
  logic                ev_void, ev_match, ev_tail, ev_bad;

  ecap_add_check #(
    .CFG_BYTES(CFG_BYTES), .BASE_OFF(BASE_OFF), .MIN_SIZE(MIN_SIZE),
    .OFF_W(OFF_W), .SIZE_W(SIZE_W)
  ) u_add_check (
    .off (cmd_off),
    .size(cmd_size),
    .ok  (add_ok)
  );

  ecap_hop_eval #(
    .CFG_BYTES(CFG_BYTES), .BASE_OFF(BASE_OFF), .OFF_W(OFF_W)
  ) u_hop_eval (
    .hdr     (ecap_hdr_t'(mem_rdata)),
    .cur     (cur_off),
    .key     (key),
    .match_en(match_en),
    .at_void (ev_void),
    .match   (ev_match),
    .tail    (ev_tail),
    .bad_link(ev_bad)
  );

  ecap_walk_seq #(
    .BASE_OFF(BASE_OFF), .MAX_STEPS(MAX_STEPS), .OFF_W(OFF_W), .SIZE_W(SIZE_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready),
    .cmd_op   (cmd_op),
    .cmd_id   (cmd_id),
    .cmd_ver  (cmd_ver),
    .cmd_off  (cmd_off),
    .add_ok   (add_ok),
    .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready),
    .rsp_err  (rsp_err),
    .rsp_off  (rsp_off),
    .rsp_prev (rsp_prev),
    .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata),
    .cur_off  (cur_off),
    .key      (key),
    .match_en (match_en),
    .ev_void  (ev_void),
    .ev_match (ev_match),
    .ev_tail  (ev_tail),
    .ev_bad   (ev_bad)
  );
endmodule

// File: rtl/ecap_walker_chk.sv
module ecap_walker_chk #(
  parameter int CFG_BYTES = 4096,
  parameter int BASE_OFF  = 256,
  parameter int OFF_W     = 12,
  parameter int WA_W      = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             rsp_err,
  input logic [OFF_W-1:0] rsp_off,
  input logic [OFF_W-1:0] rsp_prev,
  input logic             mem_rd_en,
  input logic             mem_wr_en,
  input logic [WA_W-1:0]  mem_addr,
  input logic [31:0]      mem_wdata
);
  localparam int BASE_WA = BASE_OFF / 4;
  localparam int LAST_WA = (CFG_BYTES - 8) / 4;

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!mem_rd_en && !mem_wr_en && !rsp_valid));

  a_r12_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));

  a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_err) && $stable(rsp_off) && $stable(rsp_prev)));

  a_r11_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_off == '0 && rsp_prev == '0));

  a_r6_read_window: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (mem_addr >= WA_W'(BASE_WA) && mem_addr <= WA_W'(LAST_WA)));

  a_r8_aligned_link: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && mem_addr != WA_W'(BASE_WA)) |-> (mem_wdata[21:20] == 2'b00));
endmodule

bind ecap_walker ecap_walker_chk #(
  .CFG_BYTES(CFG_BYTES), .BASE_OFF(BASE_OFF), .OFF_W(OFF_W), .WA_W(WA_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_ready(cmd_ready),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_err  (rsp_err),
  .rsp_off  (rsp_off),
  .rsp_prev (rsp_prev),
  .mem_rd_en(mem_rd_en),
  .mem_wr_en(mem_wr_en),
  .mem_addr (mem_addr),
  .mem_wdata(mem_wdata)
);

// File: tb/ecap_walker_tb.sv
module ecap_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_op = 1'b0;
  logic [15:0] cmd_id = '0;
  logic [3:0]  cmd_ver = '0;
  logic [11:0] cmd_off = '0;
  logic [12:0] cmd_size = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic        rsp_err;
  logic [11:0] rsp_off, rsp_prev;
  logic        mem_rd_en, mem_wr_en;
  logic [9:0]  mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;

  logic [31:0] mem [0:1023];

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  logic        r_err;
  logic [11:0] r_off, r_prev;

  always #10 clk = ~clk;

  ecap_walker u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_id(cmd_id), .cmd_ver(cmd_ver), .cmd_off(cmd_off), .cmd_size(cmd_size),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_err(rsp_err),
    .rsp_off(rsp_off), .rsp_prev(rsp_prev),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Configuration memory model: one-cycle read latency.
  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= mem[mem_addr];
    if (mem_wr_en) mem[mem_addr] <= mem_wdata;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk  = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run did not complete, act %0d cycles exp fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  function automatic logic [31:0] hdr(input logic [15:0] id, input logic [3:0] ver,
                                      input logic [11:0] nxt);
    return {nxt, ver, id};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: act %h exp %h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
  endtask

  // Issue one command, wait for the response, optionally stall it.
  task automatic do_cmd(input logic op, input logic [15:0] id, input logic [3:0] ver,
                        input logic [11:0] off, input logic [12:0] size, input int hold);
    @(negedge clk);
    cmd_op = op; cmd_id = id; cmd_ver = ver; cmd_off = off; cmd_size = size;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    r_err = rsp_err; r_off = rsp_off; r_prev = rsp_prev;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_err == r_err && rsp_off == r_off && rsp_prev == r_prev,
          "R11 held response", {19'b0, rsp_valid, rsp_off}, {19'b0, 1'b1, r_off});
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic expect_rsp(input string req, input logic err, input logic [11:0] off,
                            input logic [11:0] prev);
    chk({r_err, r_off, r_prev} == {err, off, prev}, req,
        {7'b0, r_err, r_off, r_prev}, {7'b0, err, off, prev});
  endtask

  task automatic t_reset();
    chk_eq("R1 cmd_ready after reset", 32'(cmd_ready), 32'd1);
    chk_eq("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    chk_eq("R1 memory idle after reset", 32'({mem_rd_en, mem_wr_en}), 32'd0);
  endtask

  task automatic t_empty();
    clear_mem();
    do_cmd(1'b0, 16'h0005, 4'h0, 12'h0, 13'h0, 0);
    expect_rsp("R2 search on empty list", 1'b0, 12'h000, 12'h000);
    do_cmd(1'b1, 16'h0022, 4'h2, 12'h140, 13'd16, 0);
    expect_rsp("R9 append off head into empty list", 1'b1, 12'h000, 12'h000);
    chk_eq("R9 nothing written on empty-list reject", mem[12'h140 >> 2], 32'h0);
  endtask

  task automatic t_build();
    clear_mem();
    do_cmd(1'b1, 16'h0011, 4'h1, 12'h100, 13'd16, 0);
    expect_rsp("R7 append at head", 1'b0, 12'h100, 12'h000);
    chk_eq("R3 R7 head word", mem[64], hdr(16'h0011, 4'h1, 12'h000));
    do_cmd(1'b1, 16'h0022, 4'h2, 12'h140, 13'd16, 0);
    expect_rsp("R8 append second", 1'b0, 12'h140, 12'h100);
    chk_eq("R8 tail link patched", mem[64], hdr(16'h0011, 4'h1, 12'h140));
    chk_eq("R8 new header", mem[12'h140 >> 2], hdr(16'h0022, 4'h2, 12'h000));
    do_cmd(1'b1, 16'h0033, 4'h3, 12'h200, 13'd32, 0);
    expect_rsp("R8 append third", 1'b0, 12'h200, 12'h140);
    chk_eq("R8 middle link patched", mem[12'h140 >> 2], hdr(16'h0022, 4'h2, 12'h200));
    chk_eq("R3 third header", mem[12'h200 >> 2], hdr(16'h0033, 4'h3, 12'h000));
  endtask

  task automatic t_find();
    do_cmd(1'b0, 16'h0011, 4'h0, 12'h0, 13'h0, 0);
    expect_rsp("R4 match at head", 1'b0, 12'h100, 12'h000);
    do_cmd(1'b0, 16'h0022, 4'h0, 12'h0, 13'h0, 0);
    expect_rsp("R4 match in middle", 1'b0, 12'h140, 12'h100);
    do_cmd(1'b0, 16'h0033, 4'h0, 12'h0, 13'h0, 3);
    expect_rsp("R4 match at tail", 1'b0, 12'h200, 12'h140);
    do_cmd(1'b0, 16'h0044, 4'h0, 12'h0, 13'h0, 0);
    expect_rsp("R5 absent key", 1'b0, 12'h000, 12'h200);
    do_cmd(1'b0, 16'h0000, 4'h0, 12'h0, 13'h0, 0);
    expect_rsp("R5 key zero finds tail", 1'b0, 12'h000, 12'h200);
    do_cmd(1'b1, 16'h0022, 4'h5, 12'h300, 13'd8, 0);
    expect_rsp("R8 duplicate id appended", 1'b0, 12'h300, 12'h200);
    do_cmd(1'b0, 16'h0022, 4'h0, 12'h0, 13'h0, 0);
    expect_rsp("R4 first of duplicates", 1'b0, 12'h140, 12'h100);
  endtask

  task automatic t_head_replace();
    do_cmd(1'b1, 16'h0055, 4'h4, 12'h100, 13'd8, 0);
    expect_rsp("R7 append at head of list", 1'b0, 12'h100, 12'h000);
    chk_eq("R7 head next kept", mem[64], hdr(16'h0055, 4'h4, 12'h140));
  endtask

  task automatic t_reject();
    logic [31:0] tail_w;
    tail_w = mem[12'h300 >> 2];
    do_cmd(1'b1, 16'h0066, 4'h1, 12'h400, 13'd4, 0);
    expect_rsp("R9 size below 8", 1'b1, 12'h000, 12'h000);
    do_cmd(1'b1, 16'h0066, 4'h1, 12'hF00, 13'h100, 0);
    expect_rsp("R9 end reaches 4096", 1'b1, 12'h000, 12'h000);
    do_cmd(1'b1, 16'h0066, 4'h1, 12'h402, 13'd8, 0);
    expect_rsp("R9 unaligned offset", 1'b1, 12'h000, 12'h000);
    do_cmd(1'b1, 16'h0066, 4'h1, 12'h0FC, 13'd8, 0);
    expect_rsp("R9 offset below head", 1'b1, 12'h000, 12'h000);
    chk_eq("R9 tail untouched after rejects", mem[12'h300 >> 2], tail_w);
    chk_eq("R9 target untouched after rejects", mem[12'h400 >> 2], 32'h0);
    do_cmd(1'b1, 16'h0066, 4'h1, 12'hFF0, 13'd15, 0);
    expect_rsp("R9 end at 4095 accepted", 1'b0, 12'hFF0, 12'h300);
    chk_eq("R8 tail id and version kept", mem[12'h300 >> 2], hdr(16'h0022, 4'h5, 12'hFF0));
  endtask

  task automatic t_bad_links();
    clear_mem();
    mem[64] = hdr(16'h0011, 4'h1, 12'h0F0);
    do_cmd(1'b0, 16'h0099, 4'h0, 12'h0, 13'h0, 0);
    expect_rsp("R6 link below head", 1'b1, 12'h000, 12'h000);
    mem[64] = hdr(16'h0011, 4'h1, 12'hFFC);
    do_cmd(1'b0, 16'h0099, 4'h0, 12'h0, 13'h0, 0);
    expect_rsp("R6 link beyond 4088", 1'b1, 12'h000, 12'h000);
    mem[64] = hdr(16'h0011, 4'h1, 12'h142);
    do_cmd(1'b0, 16'h0099, 4'h0, 12'h0, 13'h0, 0);
    expect_rsp("R6 misaligned link", 1'b1, 12'h000, 12'h000);
    mem[64] = hdr(16'h0011, 4'h1, 12'hFF8);
    mem[12'hFF8 >> 2] = hdr(16'h0077, 4'h1, 12'h000);
    do_cmd(1'b0, 16'h0077, 4'h0, 12'h0, 13'h0, 0);
    expect_rsp("R6 link at 4088 accepted", 1'b0, 12'hFF8, 12'h100);
  endtask

  task automatic t_cycle();
    clear_mem();
    mem[64] = hdr(16'h0011, 4'h1, 12'h104);
    mem[65] = hdr(16'h0012, 4'h1, 12'h100);
    do_cmd(1'b0, 16'h0099, 4'h0, 12'h0, 13'h0, 0);
    expect_rsp("R10 pointer cycle stopped", 1'b1, 12'h000, 12'h000);
    do_cmd(1'b0, 16'h0012, 4'h0, 12'h0, 13'h0, 0);
    expect_rsp("R12 engine usable after cycle", 1'b0, 12'h104, 12'h100);
  endtask

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_empty();
    t_build();
    t_find();
    t_head_replace();
    t_reject();
    t_bad_links();
    t_cycle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule